// File: doc/BRIEF.md
# Asynchronous SRAM Write-Cycle Sequencer

This block is a synchronous controller for the control pins of an external asynchronous static RAM, used for write transfers only. A host hands over one write at a time, with address and data, on a valid/ready port. The sequencer then drives the address bus, the chip-enable, the write strobe, the output-enable and the data-bus driver enable in a fixed order. Each interval in that order lasts a whole number of clock cycles, and every length is a module parameter of at least one cycle.

Two configuration inputs set the shape of each transfer. The first selects which enable goes low last and so starts the write: the write strobe (strobe-controlled) or the chip-enable (enable-controlled). The second selects whether the memory's output-enable stays low or high during the write. The sequencer samples both inputs when it accepts a request and holds them for the rest of that transfer.

The write window is the time that chip-enable and write strobe are both low. The length of that window, and the cycle in which the controller starts driving data, depend on the configuration. The aim is that the controller and the memory never drive the data pins in the same cycle, and that data meets its setup and hold times around the rising edge that ends the write.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset the port shows `req_ready` = 1, `mem_ce_n` = 1, `mem_we_n` = 1, `mem_oe_n` = 1 and `mem_dq_oe` = 0.
- R2: `mem_addr` takes the request address in the cycle after acceptance (`req_valid` and `req_ready` high at a clock edge). It does not change again until `req_ready` has returned high, so it never moves while both enables are low.
- R3: Each transfer starts with T_AS setup cycles in which exactly one enable is low. With `cfg_ce_last` = 0 (strobe-controlled) that enable is chip-enable and the write strobe falls last. With `cfg_ce_last` = 1 (enable-controlled) it is the write strobe and chip-enable falls last.
- R4: Both enables stay low together for max(T_WP, T_WZ+T_DW) cycles in strobe-controlled mode with `cfg_oe_low` = 1. In every other configuration they stay low together for max(T_WP, T_DW) cycles.
- R5: Chip-enable and write strobe return high in the same cycle, which ends the write window.
- R6: In strobe-controlled mode with `cfg_oe_low` = 1, `mem_dq_oe` rises T_WZ cycles into the write window. In every other configuration it rises in the window's first cycle. It stays high for exactly T_DH cycles after the enables rise. It is never high while chip-enable is low, the write strobe is high and output-enable is low.
- R7: `req_ready` returns high max(T_DH, T_WR) cycles after the enables rise. A request held valid during a transfer is not accepted before then.
- R8: `mem_oe_n` equals the inverse of `cfg_oe_low` as sampled at acceptance, for the whole transfer.
- R9: Changes on `cfg_ce_last` or `cfg_oe_low` after acceptance have no effect on the transfer in progress.
- R10: Whenever `mem_dq_oe` is high, `mem_dq_out` equals the accepted request data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host has a write request |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | ADDR_W | Request address |
| req_data | input | DATA_W | Request write data |
| cfg_ce_last | input | 1 | 1: chip-enable falls last; 0: write strobe falls last |
| cfg_oe_low | input | 1 | 1: memory output-enable held low during the write |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Memory chip-enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output-enable, active low |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable of the data-bus driver |

## Verification
The hardest case to reach is strobe-controlled mode with output-enable low. Here the memory is still driving the data pins when the write window opens, so the controller must wait before it drives. That case is the only one that uses the longer write window. The bench reaches it directly by selecting that configuration at acceptance. It then measures from the pins which cycle of the window the driver turns on in, and how many cycles it stays on before and after the enables rise. A further run changes both configuration inputs in the cycle after acceptance, to show that the transfer keeps the shape it was accepted with.

// File: rtl/srw_pkg.sv
// Shared types and helpers for the SRAM write sequencer.
// Assumes: all timing values are whole clock cycles, at least 1.
package srw_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_PULSE = 2'd2,
        PH_RECOV = 2'd3
    } srw_phase_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/srw_ctrl.sv
// Phase controller: steps IDLE -> SETUP -> PULSE -> RECOV -> IDLE and
// keeps a count of the cycles spent in the current phase. It latches the
// mode bits at acceptance so that they stay fixed for the whole transfer.
// Assumes: T_* parameters >= 1.
module srw_ctrl
    import srw_pkg::*;
#(
    parameter int T_AS = 2,
    parameter int T_WP = 3,
    parameter int T_WZ = 2,
    parameter int T_DW = 2,
    parameter int T_DH = 1,
    parameter int T_WR = 3,
    parameter int CW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          cfg_ce_last,
    input  logic          cfg_oe_low,
    output srw_phase_e    phase,
    output logic [CW-1:0] elapsed,
    output logic          accept,
    output logic          md_ce,
    output logic          md_oe
);
    localparam int PULSE_LONG  = max2(T_WP, T_WZ + T_DW);
    localparam int PULSE_SHORT = max2(T_WP, T_DW);
    localparam int RECOV_LEN   = max2(T_DH, T_WR);

    logic [CW-1:0] last_cnt;
    logic          phase_done;

    assign accept = (phase == PH_IDLE) && req_valid;

    // Last count value of the current phase, from the latched mode
    always_comb begin
        case (phase)
            PH_SETUP: last_cnt = CW'(T_AS - 1);
            PH_PULSE: last_cnt = (!md_ce && md_oe) ? CW'(PULSE_LONG - 1)
                                                   : CW'(PULSE_SHORT - 1);
            PH_RECOV: last_cnt = CW'(RECOV_LEN - 1);
            default:  last_cnt = '0;
        endcase
    end

    assign phase_done = (elapsed == last_cnt);

    // Advance the phase and the cycle count within the phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            elapsed <= '0;
        end else if (phase == PH_IDLE) begin
            elapsed <= '0;
            if (accept) phase <= PH_SETUP;
        end else if (phase_done) begin
            elapsed <= '0;
            case (phase)
                PH_SETUP: phase <= PH_PULSE;
                PH_PULSE: phase <= PH_RECOV;
                default:  phase <= PH_IDLE;
            endcase
        end else begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // Capture the mode bits when a request is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            md_ce <= 1'b0;
            md_oe <= 1'b0;
        end else if (accept) begin
            md_ce <= cfg_ce_last;
            md_oe <= cfg_oe_low;
        end
    end
endmodule

// File: rtl/srw_pins.sv
// Pin stage: holds the address and data of the transfer and decodes the
// memory control pins from the phase and cycle count.
// Assumes: phase and elapsed come from srw_ctrl with the same T_* values.
module srw_pins
    import srw_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int T_WZ   = 2,
    parameter int T_DH   = 1,
    parameter int CW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  srw_phase_e        phase,
    input  logic [CW-1:0]     elapsed,
    input  logic              md_ce,
    input  logic              md_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_dq_oe
);
    // Latch address and data on acceptance only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_data;
        end
    end

    // Enable order: the enable picked to fall last stays high during setup
    always_comb begin
        mem_ce_n = 1'b1;
        mem_we_n = 1'b1;
        case (phase)
            PH_SETUP: begin
                mem_ce_n = md_ce;
                mem_we_n = !md_ce;
            end
            PH_PULSE: begin
                mem_ce_n = 1'b0;
                mem_we_n = 1'b0;
            end
            default: ;
        endcase
    end

    // Data driver: wait out the memory's turn-off delay only when it drives
    always_comb begin
        case (phase)
            PH_PULSE: mem_dq_oe = md_ce || !md_oe || (elapsed >= CW'(T_WZ));
            PH_RECOV: mem_dq_oe = (elapsed < CW'(T_DH));
            default:  mem_dq_oe = 1'b0;
        endcase
    end

    assign mem_oe_n = !md_oe;
endmodule

// File: rtl/sram_wr_seq.sv
// Top of the SRAM write sequencer: a valid/ready host port in front, the
// memory pins behind. Connects the phase controller to the pin stage.
// Assumes: one transfer at a time; T_* parameters >= 1.
module sram_wr_seq
    import srw_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int T_AS   = 2,
    parameter int T_WP   = 3,
    parameter int T_WZ   = 2,
    parameter int T_DW   = 2,
    parameter int T_DH   = 1,
    parameter int T_WR   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              cfg_ce_last,
    input  logic              cfg_oe_low,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);
    localparam int MAX_LEN = max2(max2(T_AS, max2(T_WP, T_WZ + T_DW)),
                                  max2(T_DH, T_WR));
    localparam int CW = $clog2(MAX_LEN + 1);

    srw_phase_e    phase;
    logic [CW-1:0] elapsed;
    logic          accept;
    logic          md_ce_q;
    logic          md_oe_q;

    assign req_ready = (phase == PH_IDLE);

    srw_ctrl #(
        .T_AS(T_AS), .T_WP(T_WP), .T_WZ(T_WZ), .T_DW(T_DW),
        .T_DH(T_DH), .T_WR(T_WR), .CW(CW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .cfg_ce_last(cfg_ce_last), .cfg_oe_low(cfg_oe_low),
        .phase(phase), .elapsed(elapsed), .accept(accept),
        .md_ce(md_ce_q), .md_oe(md_oe_q)
    );

    srw_pins #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_WZ(T_WZ), .T_DH(T_DH), .CW(CW)
    ) u_pins (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .req_addr(req_addr), .req_data(req_data),
        .phase(phase), .elapsed(elapsed), .md_ce(md_ce_q), .md_oe(md_oe_q),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
    );
endmodule

// File: rtl/srw_chk.sv
// Property checker for sram_wr_seq, observing only the pins and the latched
// mode bit. Assumes the synchronous active-low reset of the design.
module srw_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe,
    input logic              md_ce
);
    // R2
    addr_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(mem_addr));

    // R2
    addr_window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !mem_we_n) |=> $stable(mem_addr));

    // R3
    ce_falls_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ce_n) && md_ce) |-> !mem_we_n);

    // R3
    we_falls_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_we_n) && !md_ce) |-> !mem_ce_n);

    // R5
    we_rise_joint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_ce_n);

    // R5
    ce_rise_joint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> mem_we_n);

    // R6
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !(!mem_ce_n && mem_we_n && !mem_oe_n));

    // R7
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && !mem_dq_oe));
endmodule

bind sram_wr_seq srw_chk #(.ADDR_W(ADDR_W)) u_srw_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_oe(mem_dq_oe), .md_ce(md_ce_q)
);

// File: tb/sim_sram_wr_seq.sv
// Directed bench for sram_wr_seq: every transfer is measured at the pins.
module sim_sram_wr_seq;
    localparam int AW = 11, DW = 8;
    localparam int T_AS = 2, T_WP = 3, T_WZ = 2, T_DW = 2, T_DH = 1, T_WR = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          cfg_ce_last = 1'b0;
    logic          cfg_oe_low = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = !clk;

    sram_wr_seq #(
        .ADDR_W(AW), .DATA_W(DW), .T_AS(T_AS), .T_WP(T_WP), .T_WZ(T_WZ),
        .T_DW(T_DW), .T_DH(T_DH), .T_WR(T_WR)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .cfg_ce_last(cfg_ce_last),
        .cfg_oe_low(cfg_oe_low), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe)
    );

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One transfer, measured cycle by cycle at the pins; flip changes the
    // mode inputs right after acceptance
    task automatic run_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input bit ce_last, input bit oe_low, input bit flip);
        int n_setup = 0, n_pulse = 0, n_drv = 0, first_drv = -1;
        int n_post = 0, n_hold = 0, bad_order = 0, bad_addr = 0;
        int bad_data = 0, bad_oe = 0, late_drv = 0;
        int exp_pulse, exp_first;
        exp_pulse = (!ce_last && oe_low) ? mx(T_WP, T_WZ + T_DW) : mx(T_WP, T_DW);
        exp_first = (!ce_last && oe_low) ? T_WZ : 0;
        @(negedge clk);
        cfg_ce_last = ce_last; cfg_oe_low = oe_low;
        req_addr = a; req_data = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (flip) begin cfg_ce_last = !ce_last; cfg_oe_low = !oe_low; end
        for (int i = 0; i < 100; i++) begin
            if (mem_ce_n && mem_we_n && req_ready) break;
            if (mem_addr != a) bad_addr++;
            if (mem_oe_n != !oe_low) bad_oe++;
            if (mem_dq_oe && mem_dq_out != d) bad_data++;
            if (!mem_ce_n && !mem_we_n) begin
                n_pulse++;
                if (mem_dq_oe) begin
                    if (first_drv < 0) first_drv = n_pulse - 1;
                    n_drv++;
                end
            end else if (mem_ce_n != mem_we_n) begin
                n_setup++;
                if (mem_ce_n != ce_last) bad_order++;
            end else begin
                n_post++;
                if (mem_dq_oe) begin
                    n_hold++;
                    if (n_post > T_DH) late_drv++;
                end
            end
            @(negedge clk);
        end
        check(n_setup == T_AS, "R3 setup cycles", n_setup, T_AS);
        check(bad_order == 0, "R3 enable order", bad_order, 0);
        check(n_pulse == exp_pulse, "R4 window cycles", n_pulse, exp_pulse);
        check(first_drv == exp_first, "R6 drive start", first_drv, exp_first);
        check(n_drv == exp_pulse - exp_first, "R6 drive in window", n_drv, exp_pulse - exp_first);
        check(n_hold == T_DH && late_drv == 0, "R6 drive hold", n_hold, T_DH);
        check(n_post == mx(T_DH, T_WR), "R7 recovery cycles", n_post, mx(T_DH, T_WR));
        check(bad_addr == 0, "R2 address held", bad_addr, 0);
        check(bad_oe == 0, "R8 OE level", bad_oe, 0);
        check(bad_data == 0, "R10 data value", bad_data, 0);
        if (flip) check(bad_order == 0 && n_pulse == exp_pulse, "R9 mode change ignored", n_pulse, exp_pulse);
    endtask

    task automatic test_reset();
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(mem_ce_n && mem_we_n, "R1 enables high", {mem_ce_n, mem_we_n}, 3);
        check(mem_oe_n == 1'b1, "R1 OE high", mem_oe_n, 1);
        check(mem_dq_oe == 1'b0, "R1 drive off", mem_dq_oe, 0);
    endtask

    // A second request is held valid during a transfer: it must wait
    task automatic test_held_off();
        int early = 0, moved = 0, busy = 0;
        @(negedge clk);
        cfg_ce_last = 1'b0; cfg_oe_low = 1'b0;
        req_addr = 11'h155; req_data = 8'h3C; req_valid = 1'b1;
        @(negedge clk);
        req_addr = 11'h2AA; req_data = 8'hC3;
        for (int i = 0; i < 100; i++) begin
            if (req_ready) break;
            busy++;
            if (mem_addr != 11'h155) moved++;
            @(negedge clk);
        end
        check(moved == 0, "R7 held-off address", moved, 0);
        check(busy == T_AS + mx(T_WP, T_DW) + mx(T_DH, T_WR), "R7 busy length",
              busy, T_AS + mx(T_WP, T_DW) + mx(T_DH, T_WR));
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_addr == 11'h2AA && !req_ready, "R2 second accepted", mem_addr, 11'h2AA);
        for (int i = 0; i < 100; i++) begin
            if (req_ready) break;
            if (mem_ce_n && mem_we_n && mem_dq_oe && early == 0) early = 0;
            @(negedge clk);
        end
        check(req_ready == 1'b1, "R7 ready after second", req_ready, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        run_write(11'h001, 8'hA5, 1'b0, 1'b1, 1'b0);
        run_write(11'h7FE, 8'h5A, 1'b0, 1'b0, 1'b0);
        run_write(11'h400, 8'hFF, 1'b1, 1'b1, 1'b0);
        run_write(11'h3FF, 8'h00, 1'b1, 1'b0, 1'b0);
        run_write(11'h123, 8'h81, 1'b0, 1'b1, 1'b1);
        run_write(11'h456, 8'h18, 1'b1, 1'b0, 1'b1);
        test_held_off();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule